// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Masked Interrupt

This block is a byte-wide asynchronous serial port that a host reaches through a small word-addressed register bus. The host writes a byte into a one-entry transmit holding register, and the block frames and shifts it out on `txd`. The block samples `rxd`, rebuilds each incoming frame and leaves the byte in a one-entry receive holding register. A status word reports readiness, sticky error conditions and the clear-to-send line. A control word enables interrupts bit for bit against the status word, forces the line into a break and drives the request-to-send output.

A frame is one low start bit, eight data bits sent least significant first, an optional parity bit chosen at build time, and one high stop bit. A programmable divisor sets the bit period in system clocks. A host uses the block by polling the status word or by enabling interrupt sources. It clears accumulated errors by writing any value to the status word.

Top module: `mmuart_top`

## Requirements
- R1: Word addresses on `bus_addr` are 0 receive data, 1 transmit data, 2 status, 3 control (13 bits), 4 divisor, 5 end-of-packet character (8 bits, storage only). Reads of 1, 6 and 7 return 0, and `bus_rdata` is 0 when no read is strobed. After reset the status reads 0x0060, control 0, divisor the `DIV_RESET` parameter, end-of-packet 0, with `txd` high and `rts` low.
- R2: A transmitted frame on `txd` is a low start bit, data bits 0..7, then the parity bit when `PARITY_MODE` is 1 (even: XOR of the data) or 2 (odd: its inverse), then a high stop bit. Each bit lasts the divisor value in clocks, and values below 2 act as 2.
- R3: Status bit 6 (transmit ready) is 1 while the transmit holding register is empty. Status bit 5 (shifter empty) is 1 only when the holding register and the shifter are both idle.
- R4: A transmit-data write while bit 6 is 0 sets status bit 4 (transmit overrun), and that byte is never sent.
- R5: A completed received frame loads its data byte and sets status bit 7 (receive ready). A read of word 0 returns the byte and clears bit 7, unless a new byte completes in that same cycle.
- R6: A frame that completes while bit 7 is still 1 and no receive-data read occurs sets status bit 3 (receive overrun), and the newer byte replaces the held one.
- R7: Status bit 0 sets on a received parity mismatch, and bit 1 sets when the stop bit is sampled low. Bit 2 (break) sets when the data, the parity bit if present and the stop bit are all zero. A break also sets bit 1.
- R8: Status bit 8 is the OR of status bits 0 through 4.
- R9: Any write to word 2 clears status bits 0, 1, 2, 3, 4 and 10. A flag whose setting event arrives in the same cycle as the write stays set.
- R10: Status bit 11 follows `cts` after a two-stage synchronizer. Status bit 10 sets on every change of the synchronized level.
- R11: `irq` is 1 exactly when some status bit in positions 0–8, 10 or 12 is 1 together with the control bit in the same position. Control bits 9 and 11 never raise `irq`. Status bit 12 always reads 0.
- R12: While control bit 9 is 1, `txd` is held low. `rts` equals control bit 11.
- R13: The receiver looks for a low level, re-checks it after half a bit period and samples each later bit near its middle. A low pulse shorter than half a bit produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 3 | Word address inside the 32-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Clear-to-send level (asynchronous) |
| rts | output | 1 | Request-to-send level |
| irq | output | 1 | Level interrupt |

## Verification
Transmit overrun is the hardest condition to reach from the ports. The holding register stays full only while the previous byte is still shifting, so a third write must land in that short span while the line is being watched. The bench solves this with two parallel branches: one decodes two frames from `txd`, and the other issues three back-to-back writes and reads the status between them. Afterwards it watches the idle line to confirm that the rejected byte never appears. Receive overrun is reached the same way, by sending two frames back to back without a read in between.

// File: rtl/mmuart_pkg.sv
package mmuart_pkg;

    localparam int BUS_W = 16;

    // word addresses inside the 32-byte window
    localparam logic [2:0] A_RXDATA = 3'd0;
    localparam logic [2:0] A_TXDATA = 3'd1;
    localparam logic [2:0] A_STATUS = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_DIV    = 3'd4;
    localparam logic [2:0] A_EOP    = 3'd5;

    localparam int CTRL_W    = 13;
    localparam int C_BRK_TX  = 9;
    localparam int C_RTS     = 11;

    // status positions that may raise the interrupt (0..8, 10, 12)
    localparam logic [BUS_W-1:0] IRQ_EN_MASK = 16'h15FF;

    // status word, msb first; field position is the bit position
    typedef struct packed {
        logic [2:0] rsvd_hi;
        logic       eop;
        logic       cts_lvl;
        logic       cts_chg;
        logic       rsvd9;
        logic       exc;
        logic       rrdy;
        logic       trdy;
        logic       tmt;
        logic       toe;
        logic       roe;
        logic       brk;
        logic       fe;
        logic       pe;
    } status_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_word_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLDOFF
    } rx_state_t;

    // mode 1 even, mode 2 odd
    function automatic logic par_of(logic [7:0] d, int mode);
        return (mode == 2) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/mmuart_rx.sv
module mmuart_rx
    import mmuart_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int PARITY_MODE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd_async,
    input  logic [DIV_W-1:0] period,
    output logic             rx_done,
    output rx_word_t         rx_out
);
    localparam logic HAS_PAR = (PARITY_MODE != 0);

    logic [1:0]       sy;
    logic             rx_s;
    rx_state_t        rx_st;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] last;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             par_q;
    logic             done_q;
    rx_word_t         out_q;

    assign rx_s = sy[1];
    assign half = period >> 1;
    assign last = period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy     <= 2'b11;
            rx_st  <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            par_q  <= 1'b0;
            done_q <= 1'b0;
            out_q  <= '0;
        end else begin
            sy     <= {sy[0], rxd_async};
            done_q <= 1'b0;
            case (rx_st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        rx_st <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == half - 1'b1) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        rx_st <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == last) begin
                        cnt  <= '0;
                        sh   <= {rx_s, sh[7:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) rx_st <= HAS_PAR ? RX_PAR : RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == last) begin
                        cnt   <= '0;
                        par_q <= rx_s;
                        rx_st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == last) begin
                        cnt        <= '0;
                        done_q     <= 1'b1;
                        out_q.data <= sh;
                        out_q.perr <= HAS_PAR && (par_q != par_of(sh, PARITY_MODE));
                        out_q.ferr <= !rx_s;
                        out_q.brk  <= !rx_s && (sh == 8'h00) && !(HAS_PAR && par_q);
                        rx_st      <= rx_s ? RX_IDLE : RX_HOLDOFF;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_HOLDOFF: begin
                    if (rx_s) rx_st <= RX_IDLE;
                end
                default: rx_st <= RX_IDLE;
            endcase
        end
    end

    assign rx_done = done_q;
    assign rx_out  = out_q;

endmodule

// File: rtl/mmuart_tx.sv
module mmuart_tx
    import mmuart_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int PARITY_MODE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] period,
    input  logic             load,
    input  logic [7:0]       load_byte,
    input  logic             force_low,
    output logic             txd,
    output logic             busy
);
    localparam int FRAME_W = (PARITY_MODE == 0) ? 10 : 11;
    localparam int IDX_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] sh;
    logic [DIV_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               line_q;
    logic               busy_q;

    generate
        if (PARITY_MODE == 0) begin : g_nopar
            assign frame = {1'b1, load_byte, 1'b0};
        end else begin : g_par
            assign frame = {1'b1, par_of(load_byte, PARITY_MODE), load_byte, 1'b0};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            cnt    <= '0;
            idx    <= '0;
            line_q <= 1'b1;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (load) begin
                sh     <= frame;
                line_q <= frame[0];
                busy_q <= 1'b1;
                cnt    <= '0;
                idx    <= '0;
            end
        end else if (cnt == period - 1'b1) begin
            cnt <= '0;
            if (idx == IDX_W'(FRAME_W - 1)) begin
                busy_q <= 1'b0;
                line_q <= 1'b1;
            end else begin
                idx    <= idx + 1'b1;
                sh     <= sh >> 1;
                line_q <= sh[1];
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign txd  = line_q & ~force_low;
    assign busy = busy_q;

endmodule

// File: rtl/mmuart_top.sv
module mmuart_top
    import mmuart_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DIV_RESET   = 434,
    parameter int PARITY_MODE = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts,
    output logic        rts,
    output logic        irq
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  period;
    logic [7:0]        eop_q;
    logic [7:0]        hold_q;
    logic              hold_vld;
    logic [7:0]        rx_byte_q;
    logic              rrdy_q;
    logic              pe_q, fe_q, brk_q, roe_q, toe_q, dcts_q;
    logic [2:0]        cts_sy;
    logic              cts_chg;

    logic              wr_any, wr_tx, wr_st, wr_ctrl, wr_div, wr_eop, rd_rx;
    logic              rx_done;
    rx_word_t          rx_out;
    logic              tx_busy, tx_load;
    status_t           st;
    logic [BUS_W-1:0]  st_bits;

    assign wr_any  = bus_sel & bus_wr;
    assign wr_tx   = wr_any && (bus_addr == A_TXDATA);
    assign wr_st   = wr_any && (bus_addr == A_STATUS);
    assign wr_ctrl = wr_any && (bus_addr == A_CTRL);
    assign wr_div  = wr_any && (bus_addr == A_DIV);
    assign wr_eop  = wr_any && (bus_addr == A_EOP);
    assign rd_rx   = bus_sel && bus_rd && (bus_addr == A_RXDATA);

    assign period  = (div_q < MIN_DIV) ? MIN_DIV : div_q;
    assign tx_load = hold_vld & ~tx_busy;
    assign cts_chg = cts_sy[1] ^ cts_sy[2];

    mmuart_rx #(.DIV_W(DIV_W), .PARITY_MODE(PARITY_MODE)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rxd_async (rxd),
        .period    (period),
        .rx_done   (rx_done),
        .rx_out    (rx_out)
    );

    mmuart_tx #(.DIV_W(DIV_W), .PARITY_MODE(PARITY_MODE)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .period    (period),
        .load      (tx_load),
        .load_byte (hold_q),
        .force_low (ctrl_q[C_BRK_TX]),
        .txd       (txd),
        .busy      (tx_busy)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
            eop_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr_eop)  eop_q  <= bus_wdata[7:0];
        end
    end

    // holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_vld  <= 1'b0;
            rx_byte_q <= '0;
            rrdy_q    <= 1'b0;
        end else begin
            if (tx_load) begin
                hold_vld <= 1'b0;
            end else if (wr_tx && !hold_vld) begin
                hold_vld <= 1'b1;
                hold_q   <= bus_wdata[7:0];
            end
            if (rx_done) begin
                rrdy_q    <= 1'b1;
                rx_byte_q <= rx_out.data;
            end else if (rd_rx) begin
                rrdy_q <= 1'b0;
            end
        end
    end

    // sticky flags: a setting event outranks a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            brk_q  <= 1'b0;
            roe_q  <= 1'b0;
            toe_q  <= 1'b0;
            dcts_q <= 1'b0;
            cts_sy <= '0;
        end else begin
            cts_sy <= {cts_sy[1:0], cts};
            pe_q   <= (pe_q  & ~wr_st) | (rx_done & rx_out.perr);
            fe_q   <= (fe_q  & ~wr_st) | (rx_done & rx_out.ferr);
            brk_q  <= (brk_q & ~wr_st) | (rx_done & rx_out.brk);
            roe_q  <= (roe_q & ~wr_st) | (rx_done & rrdy_q & ~rd_rx);
            toe_q  <= (toe_q & ~wr_st) | (wr_tx & hold_vld);
            dcts_q <= (dcts_q & ~wr_st) | cts_chg;
        end
    end

    always_comb begin
        st         = '0;
        st.pe      = pe_q;
        st.fe      = fe_q;
        st.brk     = brk_q;
        st.roe     = roe_q;
        st.toe     = toe_q;
        st.tmt     = ~hold_vld & ~tx_busy;
        st.trdy    = ~hold_vld;
        st.rrdy    = rrdy_q;
        st.exc     = pe_q | fe_q | brk_q | roe_q | toe_q;
        st.cts_chg = dcts_q;
        st.cts_lvl = cts_sy[1];
        st.eop     = 1'b0;
    end

    assign st_bits = st;
    assign irq     = |(st_bits & {{(BUS_W-CTRL_W){1'b0}}, ctrl_q} & IRQ_EN_MASK);
    assign rts     = ctrl_q[C_RTS];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bus_rd) begin
            case (bus_addr)
                A_RXDATA: bus_rdata = {8'h00, rx_byte_q};
                A_STATUS: bus_rdata = st_bits;
                A_CTRL:   bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
                A_DIV:    bus_rdata = BUS_W'(div_q);
                A_EOP:    bus_rdata = {8'h00, eop_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mmuart_chk.sv
module mmuart_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        txd,
    input logic        rts,
    input logic        irq,
    input logic        rx_done,
    input logic        cts_chg,
    input logic [15:0] st_bits,
    input logic [12:0] ctrl_q
);
    logic wr_tx, wr_st, wr_ctrl, rd_rx;
    assign wr_tx   = bus_sel && bus_wr && (bus_addr == 3'd1);
    assign wr_st   = bus_sel && bus_wr && (bus_addr == 3'd2);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == 3'd3);
    assign rd_rx   = bus_sel && bus_rd && (bus_addr == 3'd0);

    AST_TMT_NEEDS_TRDY: assert property (@(posedge clk) disable iff (rst)
        st_bits[5] |-> st_bits[6]); // R3

    AST_TOE_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && !st_bits[6]) |=> st_bits[4]); // R4

    AST_RRDY_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_done) |=> !st_bits[7]); // R5

    AST_CLR_ERRORS: assert property (@(posedge clk) disable iff (rst)
        (wr_st && !rx_done && !cts_chg) |=> (st_bits[4:0] == 5'd0 && !st_bits[8] && !st_bits[10])); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[8:0] == 9'd0 && !ctrl_q[10] && !ctrl_q[12]) |-> !irq); // R11

    AST_BRK_HOLDS_TXD: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[9]) |=> !txd); // R12

    AST_RTS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (rts == $past(bus_wdata[11]))); // R12

endmodule

bind mmuart_top mmuart_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .txd       (txd),
    .rts       (rts),
    .irq       (irq),
    .rx_done   (rx_done),
    .cts_chg   (cts_chg),
    .st_bits   (st_bits),
    .ctrl_q    (ctrl_q)
);

// File: tb/mmuart_top_tb.sv
module mmuart_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        cts = 1'b0;
    logic        rts;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cur_div = 8;

    mmuart_top #(.DIV_W(16), .DIV_RESET(8), .PARITY_MODE(1)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .cts(cts), .rts(rts), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_div(input int dv);
        bus_write(3'd4, 16'(dv));
        cur_div = dv;
    endtask

    // even-parity frame: start, data lsb first, parity, stop
    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, ^b, b, 1'b0};
    endfunction

    task automatic capture_frame(output logic [10:0] f);
        wait (txd == 1'b0);
        repeat (cur_div / 2) @(negedge clk);
        f[0] = txd;
        for (int i = 1; i < 11; i++) begin
            repeat (cur_div) @(negedge clk);
            f[i] = txd;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic flip, input logic stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = (^b) ^ flip;
        repeat (cur_div) @(negedge clk);
        rxd = stopv;
        repeat (cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (cur_div + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [10:0] f;
        logic [10:0] fa, fb;
        int lows;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(3'd2, d); check("R1 status reset", d, 16'h0060);
        bus_read(3'd3, d); check("R1 control reset", d, 16'h0000);
        bus_read(3'd4, d); check("R1 divisor reset", d, 16'd8);
        bus_read(3'd5, d); check("R1 eop reset", d, 16'h0000);
        check("R1 txd idle", {15'd0, txd}, 16'd1);
        check("R1 rts reset", {15'd0, rts}, 16'd0);
        check("R1 irq reset", {15'd0, irq}, 16'd0);
        bus_write(3'd5, 16'h00A5);
        bus_read(3'd5, d); check("R1 eop storage", d, 16'h00A5);
        bus_read(3'd6, d); check("R1 unused word", d, 16'h0000);
        bus_read(3'd1, d); check("R1 tx data reads zero", d, 16'h0000);
        check("R1 rdata idle", bus_rdata, 16'h0000);

        // R2 frames at several divisors, including the clamp
        foreach (fa[k]) fa[k] = 1'b0;
        bus_write(3'd4, 16'd1); cur_div = 2;
        bus_write(3'd1, 16'h00C3); capture_frame(f);
        check("R2 divisor clamp frame", {5'd0, f}, {5'd0, exp_frame(8'hC3)});
        for (int dv = 2; dv <= 5; dv++) begin
            set_div(dv);
            for (int b = 0; b < 16; b++) begin
                logic [7:0] by;
                by = 8'((b * 37 + dv) & 255);
                bus_write(3'd1, {8'h00, by});
                capture_frame(f);
                check("R2 frame small sweep", {5'd0, f}, {5'd0, exp_frame(by)});
            end
        end
        set_div(4);
        for (int b = 0; b < 256; b++) begin
            bus_write(3'd1, 16'(b));
            capture_frame(f);
            check("R2 frame full sweep", {5'd0, f}, {5'd0, exp_frame(8'(b))});
        end
        repeat (3 * cur_div) @(negedge clk);

        // R3 / R4 holding register, overrun drops the third byte
        fork
            begin
                capture_frame(fa);
                wait (txd == 1'b1);
                capture_frame(fb);
            end
            begin
                bus_write(3'd1, 16'h005A);
                bus_read(3'd2, d); check("R3 shifter busy, holding empty", d, 16'h0040);
                bus_write(3'd1, 16'h0096);
                bus_read(3'd2, d); check("R3 holding full", d, 16'h0000);
                bus_write(3'd1, 16'h00FF);
                bus_read(3'd2, d); check("R4 tx overrun flagged", d, 16'h0110);
            end
        join
        check("R4 first frame", {5'd0, fa}, {5'd0, exp_frame(8'h5A)});
        check("R4 second frame", {5'd0, fb}, {5'd0, exp_frame(8'h96)});
        lows = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check("R4 dropped byte not sent", 16'(lows), 16'd0);
        bus_read(3'd2, d); check("R3 R8 idle with overrun", d, 16'h0170);
        bus_write(3'd2, 16'h0000);
        bus_read(3'd2, d); check("R9 clear tx overrun", d, 16'h0060);

        // R12 break and rts
        bus_write(3'd3, 16'h0200);
        check("R12 break holds txd low", {15'd0, txd}, 16'd0);
        repeat (20) @(negedge clk);
        check("R12 break still low", {15'd0, txd}, 16'd0);
        bus_write(3'd3, 16'h0000);
        check("R12 break released", {15'd0, txd}, 16'd1);

        // R5 receive sweep
        for (int b = 0; b < 256; b++) begin
            send_rx(8'(b), 1'b0, 1'b1);
            bus_read(3'd2, d); check("R5 rx ready", d, 16'h00E0);
            bus_read(3'd0, d); check("R5 rx data", d, 16'(b));
        end
        bus_read(3'd2, d); check("R5 read clears ready", d, 16'h0060);

        // R7 parity error with interrupt
        bus_write(3'd3, 16'h0001);
        send_rx(8'h55, 1'b1, 1'b1);
        bus_read(3'd2, d); check("R7 R8 parity error", d, 16'h01E1);
        check("R11 irq on parity", {15'd0, irq}, 16'd1);
        bus_read(3'd0, d); check("R7 data kept", d, 16'h0055);
        bus_write(3'd2, 16'h0000);
        check("R9 R11 irq clears", {15'd0, irq}, 16'd0);
        bus_write(3'd3, 16'h0000);

        // R7 framing error
        send_rx(8'h3C, 1'b0, 1'b0);
        bus_read(3'd2, d); check("R7 framing error", d, 16'h01E2);
        bus_read(3'd0, d); check("R7 framing data", d, 16'h003C);
        bus_write(3'd2, 16'h0000);

        // R7 break frame
        send_rx(8'h00, 1'b0, 1'b0);
        bus_read(3'd2, d); check("R7 break detect", d, 16'h01E6);
        bus_read(3'd0, d); check("R7 break data", d, 16'h0000);
        bus_write(3'd2, 16'h0000);
        bus_read(3'd2, d); check("R9 clear rx errors", d, 16'h0060);

        // R6 receive overrun
        send_rx(8'h12, 1'b0, 1'b1);
        send_rx(8'h34, 1'b0, 1'b1);
        bus_read(3'd2, d); check("R6 rx overrun", d, 16'h01E8);
        bus_read(3'd0, d); check("R6 newer byte kept", d, 16'h0034);
        bus_read(3'd2, d); check("R6 ready cleared, overrun stays", d, 16'h0168);
        bus_write(3'd2, 16'h0000);

        // R13 short low pulse ignored
        set_div(8);
        @(negedge clk); rxd = 1'b0;
        @(negedge clk); rxd = 1'b1;
        repeat (120) @(negedge clk);
        bus_read(3'd2, d); check("R13 glitch rejected", d, 16'h0060);
        send_rx(8'hA7, 1'b0, 1'b1);
        bus_read(3'd0, d); check("R13 frame after glitch", d, 16'h00A7);

        // R10 / R11 clear-to-send and interrupt mask
        bus_write(3'd3, 16'h0040);
        check("R11 irq on tx ready", {15'd0, irq}, 16'd1);
        bus_write(3'd3, 16'h0800);
        check("R12 rts follows control", {15'd0, rts}, 16'd1);
        @(negedge clk); cts = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(3'd2, d); check("R10 cts level and change", d, 16'h0C60);
        check("R11 rts bit excluded from irq", {15'd0, irq}, 16'd0);
        bus_write(3'd3, 16'h0400);
        check("R11 irq on cts change", {15'd0, irq}, 16'd1);
        bus_write(3'd2, 16'h0000);
        bus_read(3'd2, d); check("R9 clear cts change", d, 16'h0860);
        check("R11 irq after clear", {15'd0, irq}, 16'd0);
        @(negedge clk); cts = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(3'd2, d); check("R10 cts fall", d, 16'h0460);
        check("R11 irq on cts fall", {15'd0, irq}, 16'd1);
        bus_write(3'd3, 16'h0000);
        check("R12 rts low", {15'd0, rts}, 16'd0);

        summary();
        $finish;
    end

endmodule